// File: doc/BRIEF.md
# Tile Shape Configuration Controller

This block keeps the shape of each register in a small bank of two-dimensional matrix tiles: how many rows each tile has and how many bytes each row carries. Software-side logic hands it a 64-byte configuration image one byte per cycle. The block assembles the image in a staging area and checks it once the whole image has arrived. It then either commits the image, returns to the init state, or raises a fault and leaves the active shape as it was.

The tile data store sits next to this block and takes two signals from it. The first is the per-tile shape outputs. The second is a zero request, a single-cycle pulse that asks the store to clear every tile. The controller can also stream the active configuration back out as the same 64-byte image. A release command drops the configuration and clears the tile data, whatever the block was doing.

Image layout (byte index within the image):

- Byte 0 is the palette.
- Bytes 1 to 15 are reserved and must be zero.
- Tile t's bytes-per-row value is a 16-bit little-endian number at bytes 16+2t and 17+2t.
- Tile t's row count is byte 48+t.
- All other bytes are ignored.

Top module: `tile_shape_cfg`

## Requirements
- R1: Reset leaves the block in the init state: `cfg_valid` low, every row count and bytes-per-row output zero, and `fault`, `zero_req` and `rd_valid` low.
- R2: Load bytes are numbered 0 to 63 in the order they are accepted on `ld_valid`. The field outputs do not change while an image is arriving. A commit takes effect on the outputs in the cycle after the 64th byte is accepted, and the next accepted byte is byte 0 of a new image.
- R3: A valid image with palette 1 sets `cfg_valid` high. Tile t then shows row count = byte 48+t and bytes-per-row = {byte 17+2t, byte 16+2t}.
- R4: An image with palette 0 is always accepted, whatever its other bytes hold. It clears every shape output, drives `cfg_valid` low and raises all bits of `zero_req` for exactly one cycle, with no fault.
- R5: An image is invalid if any of the following holds:
  - the palette is above 1;
  - any of bytes 1 to 15 is nonzero;
  - a row count is above 16;
  - a bytes-per-row value is above 64;
  - a bytes-per-row value has either of its two low bits set.

  An invalid image pulses `fault` for one cycle and leaves `cfg_valid` and every shape output unchanged.
- R6: Bytes 32 to 47 and 56 to 63 have no effect and are never validated. Neither are the bytes-per-row bytes of tiles at or above NUM_TILES.
- R7: `release_req` returns the block to the init state, pulses `zero_req` on all tiles for one cycle and discards any partly received image. If it coincides with the 64th byte, the release wins and that image is neither committed nor faulted.
- R8: An `rd_start` sampled while idle produces exactly 64 consecutive cycles of `rd_valid`, starting the next cycle, with `rd_byte` carrying the image bytes in index order. Byte 0 reads 1 when configured, the field bytes follow the R3 layout and every other byte reads zero. An `rd_start` seen during a readback is ignored.
- R9: A readback taken while unconfigured returns 64 zero bytes.
- R10: Row count 16 and bytes-per-row 64 are accepted, as are zero rows and zero bytes-per-row (an unused tile).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_valid | input | 1 | Load byte strobe |
| ld_byte | input | 8 | Load byte |
| release_req | input | 1 | Return to init state and clear tiles |
| rd_start | input | 1 | Start a 64-byte readback |
| rd_valid | output | 1 | Readback byte valid |
| rd_byte | output | 8 | Readback byte |
| tile_rows | output | NUM_TILES*8 | Per-tile row count, tile t at bits [8t+7:8t] |
| tile_bpr | output | NUM_TILES*16 | Per-tile bytes per row, tile t at bits [16t+15:16t] |
| cfg_valid | output | 1 | A nonzero-palette configuration is active |
| fault | output | 1 | Single-cycle pulse on an invalid image |
| zero_req | output | NUM_TILES | Single-cycle request to zero each tile |

## Verification
Two functions can fall in the same cycle, and both collisions are provoked on purpose.

- Release against load completion: a release is asserted together with the final byte of an image that would fault, and the bench expects a zero request and init state with no fault and no commit.
- Readback against reconfiguration: a readback is started and then a release arrives mid-stream. The bench expects the remaining bytes to read as zeros, because readback follows the live configuration.

A behavioural reference model predicts every output on every cycle, so a mismatch in the cycle of either collision is caught.

// File: rtl/tcfg_pkg.sv
package tcfg_pkg;
   localparam int IMG_BYTES = 64;
   localparam int RSV_LAST  = 15;
   localparam int BPR_BASE  = 16;
   localparam int ROWS_BASE = 48;
   localparam int TILE_CAP  = 8;
   localparam int ROW_W     = 8;
   localparam int BPR_W     = 16;
   typedef logic [5:0] img_idx_t;
endpackage

// File: rtl/tcfg_loader.sv
module tcfg_loader
   import tcfg_pkg::*;
#(
   parameter int NT       = 8,
   parameter int MAX_ROWS = 16,
   parameter int MAX_BPR  = 64
)(
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        in_vld,
   input  logic [7:0]                  in_byte,
   input  logic                        abort,
   output logic                        done,
   output logic                        img_ok,
   output logic [7:0]                  pal,
   output logic [NT-1:0][ROW_W-1:0]    rows,
   output logic [NT-1:0][BPR_W-1:0]    bpr
);
   localparam logic [ROW_W-1:0] ROW_LIM = ROW_W'(MAX_ROWS);
   localparam logic [BPR_W-1:0] BPR_LIM = BPR_W'(MAX_BPR);

   img_idx_t                   idx;
   logic [7:0]                 pal_q;
   logic                       rsv_q, rsv_n;
   logic [NT-1:0][ROW_W-1:0]   rows_q;
   logic [NT-1:0][BPR_W-1:0]   bpr_q;
   logic [NT-1:0]              tile_good;

   always_comb begin
      pal   = pal_q;
      rows  = rows_q;
      bpr   = bpr_q;
      rsv_n = rsv_q;
      if (in_vld) begin
         if (idx == '0) begin
            pal   = in_byte;
            rsv_n = 1'b0;
         end else if (int'(idx) <= RSV_LAST && in_byte != 8'd0) begin
            rsv_n = 1'b1;
         end
         for (int t = 0; t < NT; t++) begin
            if (int'(idx) == BPR_BASE + 2*t)     bpr[t][7:0]  = in_byte;
            if (int'(idx) == BPR_BASE + 2*t + 1) bpr[t][15:8] = in_byte;
            if (int'(idx) == ROWS_BASE + t)      rows[t]      = in_byte;
         end
      end
   end

   for (genvar t = 0; t < NT; t++) begin : g_chk
      assign tile_good[t] = (rows[t] <= ROW_LIM) && (bpr[t] <= BPR_LIM) && (bpr[t][1:0] == 2'b00);
   end

   assign img_ok = (pal == 8'd0) || (pal == 8'd1 && !rsv_n && (&tile_good));
   assign done   = in_vld && (idx == img_idx_t'(IMG_BYTES - 1)) && !abort;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx    <= '0;
         pal_q  <= '0;
         rsv_q  <= 1'b0;
         rows_q <= '0;
         bpr_q  <= '0;
      end else if (abort) begin
         idx    <= '0;
      end else if (in_vld) begin
         idx    <= idx + 6'd1;
         pal_q  <= pal;
         rsv_q  <= rsv_n;
         rows_q <= rows;
         bpr_q  <= bpr;
      end
   end

   assert_idx_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (idx == '0));
   assert_abort_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> (idx == '0));
endmodule

// File: rtl/tcfg_readback.sv
module tcfg_readback
   import tcfg_pkg::*;
#(
   parameter int NT = 8
)(
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start,
   input  logic                      configured,
   input  logic [NT-1:0][ROW_W-1:0]  rows,
   input  logic [NT-1:0][BPR_W-1:0]  bpr,
   output logic                      out_vld,
   output logic [7:0]                out_byte
);
   logic     active;
   img_idx_t pos;
   logic [7:0] sel;

   always_comb begin
      sel = 8'd0;
      if (pos == '0) sel = {7'd0, configured};
      for (int t = 0; t < NT; t++) begin
         if (int'(pos) == BPR_BASE + 2*t)     sel = bpr[t][7:0];
         if (int'(pos) == BPR_BASE + 2*t + 1) sel = bpr[t][15:8];
         if (int'(pos) == ROWS_BASE + t)      sel = rows[t];
      end
   end

   assign out_vld  = active;
   assign out_byte = active ? sel : 8'd0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         pos    <= '0;
      end else if (active) begin
         pos <= pos + 6'd1;
         if (pos == img_idx_t'(IMG_BYTES - 1)) active <= 1'b0;
      end else if (start) begin
         active <= 1'b1;
         pos    <= '0;
      end
   end

   assert_rd_zero_unconf_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld && !configured) |-> (out_byte == 8'd0));
   assert_rd_first_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && start) |=> (out_vld && pos == '0));
endmodule

// File: rtl/tile_shape_cfg.sv
module tile_shape_cfg
   import tcfg_pkg::*;
#(
   parameter int NUM_TILES = 8,
   parameter int MAX_ROWS  = 16,
   parameter int MAX_BPR   = 64
)(
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          ld_valid,
   input  logic [7:0]                    ld_byte,
   input  logic                          release_req,
   input  logic                          rd_start,
   output logic                          rd_valid,
   output logic [7:0]                    rd_byte,
   output logic [NUM_TILES*ROW_W-1:0]    tile_rows,
   output logic [NUM_TILES*BPR_W-1:0]    tile_bpr,
   output logic                          cfg_valid,
   output logic                          fault,
   output logic [NUM_TILES-1:0]          zero_req
);
   if (NUM_TILES < 1 || NUM_TILES > TILE_CAP) begin : g_bad_tiles
      $error("NUM_TILES must be 1..8");
   end
   if (MAX_ROWS < 1 || MAX_ROWS > 255 || MAX_BPR < 4 || MAX_BPR > 65535) begin : g_bad_limits
      $error("shape limits out of field range");
   end

   logic                             ld_done, ld_ok;
   logic [7:0]                       ld_pal;
   logic [NUM_TILES-1:0][ROW_W-1:0]  ld_rows, act_rows;
   logic [NUM_TILES-1:0][BPR_W-1:0]  ld_bpr, act_bpr;

   tcfg_loader #(.NT(NUM_TILES), .MAX_ROWS(MAX_ROWS), .MAX_BPR(MAX_BPR)) u_load (
      .clk(clk), .rst_n(rst_n), .in_vld(ld_valid), .in_byte(ld_byte), .abort(release_req),
      .done(ld_done), .img_ok(ld_ok), .pal(ld_pal), .rows(ld_rows), .bpr(ld_bpr));

   tcfg_readback #(.NT(NUM_TILES)) u_rd (
      .clk(clk), .rst_n(rst_n), .start(rd_start), .configured(cfg_valid),
      .rows(act_rows), .bpr(act_bpr), .out_vld(rd_valid), .out_byte(rd_byte));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_rows  <= '0;
         act_bpr   <= '0;
         cfg_valid <= 1'b0;
         fault     <= 1'b0;
         zero_req  <= '0;
      end else begin
         fault    <= 1'b0;
         zero_req <= '0;
         if (release_req || (ld_done && ld_ok && ld_pal == 8'd0)) begin
            act_rows  <= '0;
            act_bpr   <= '0;
            cfg_valid <= 1'b0;
            zero_req  <= '1;
         end else if (ld_done && !ld_ok) begin
            fault <= 1'b1;
         end else if (ld_done) begin
            act_rows  <= ld_rows;
            act_bpr   <= ld_bpr;
            cfg_valid <= 1'b1;
         end
      end
   end

   assign tile_rows = act_rows;
   assign tile_bpr  = act_bpr;

   assert_fault_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      fault |=> !fault);
   assert_fault_keeps_cfg_R5: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> ($stable(act_rows) && $stable(act_bpr) && $stable(cfg_valid)));
   assert_cfg_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg_valid) |-> $past(ld_done && ld_ok && ld_pal == 8'd1));
   assert_zero_all_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (zero_req != '0) |-> ((&zero_req) && !cfg_valid && !fault));
   assert_release_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      release_req |=> ((&zero_req) && !fault && !cfg_valid));
   for (genvar t = 0; t < NUM_TILES; t++) begin : g_bound
      assert_shape_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
         cfg_valid |-> (act_rows[t] <= ROW_W'(MAX_ROWS) && act_bpr[t] <= BPR_W'(MAX_BPR)));
   end
endmodule

// File: tb/tile_shape_cfg_test.sv
module tile_shape_cfg_test;
   localparam int NT = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ld_valid = 1'b0;
   logic [7:0] ld_byte = 8'd0;
   logic release_req = 1'b0;
   logic rd_start = 1'b0;
   logic rd_valid;
   logic [7:0] rd_byte;
   logic [NT*8-1:0] tile_rows;
   logic [NT*16-1:0] tile_bpr;
   logic cfg_valid, fault;
   logic [NT-1:0] zero_req;

   always #4 clk = ~clk;

   tile_shape_cfg #(.NUM_TILES(NT)) uut (
      .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_byte(ld_byte),
      .release_req(release_req), .rd_start(rd_start), .rd_valid(rd_valid),
      .rd_byte(rd_byte), .tile_rows(tile_rows), .tile_bpr(tile_bpr),
      .cfg_valid(cfg_valid), .fault(fault), .zero_req(zero_req));

   int checks = 0;
   int failures = 0;
   string tag = "R1";

   // reference model state
   logic [7:0] img [64];
   logic [7:0] sbuf [64];
   int  m_idx = 0;
   bit  m_cfg = 0, m_fault = 0, m_zero = 0, m_rd = 0;
   int  m_rdi = 0;
   int  m_rows [NT];
   int  m_bpr [NT];

   function automatic logic [7:0] model_byte(int i);
      if (i == 0) return m_cfg ? 8'd1 : 8'd0;
      for (int t = 0; t < NT; t++) begin
         if (i == 16 + 2*t) return 8'(m_bpr[t] % 256);
         if (i == 17 + 2*t) return 8'(m_bpr[t] / 256);
         if (i == 48 + t)   return 8'(m_rows[t]);
      end
      return 8'd0;
   endfunction

   task automatic chk(string what, logic [127:0] act, logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      logic [NT*8-1:0]  er;
      logic [NT*16-1:0] eb;
      for (int t = 0; t < NT; t++) begin
         er[8*t +: 8]   = 8'(m_rows[t]);
         eb[16*t +: 16] = 16'(m_bpr[t]);
      end
      chk("tile_rows", 128'(tile_rows), 128'(er));
      chk("tile_bpr", 128'(tile_bpr), 128'(eb));
      chk("cfg_valid", 128'(cfg_valid), 128'(m_cfg));
      chk("fault", 128'(fault), 128'(m_fault));
      chk("zero_req", 128'(zero_req), m_zero ? 128'({NT{1'b1}}) : 128'd0);
      chk("rd_valid", 128'(rd_valid), 128'(m_rd));
      chk("rd_byte", 128'(rd_byte), m_rd ? 128'(model_byte(m_rdi)) : 128'd0);
   endtask

   task automatic clear_model();
      m_cfg = 0;
      for (int t = 0; t < NT; t++) begin m_rows[t] = 0; m_bpr[t] = 0; end
   endtask

   task automatic evaluate();
      bit ok;
      if (sbuf[0] == 8'd0) begin clear_model(); m_zero = 1; return; end
      ok = (sbuf[0] == 8'd1);
      for (int i = 1; i <= 15; i++) if (sbuf[i] != 0) ok = 0;
      for (int t = 0; t < NT; t++) begin
         int b = sbuf[16+2*t] + 256*sbuf[17+2*t];
         if (sbuf[48+t] > 16 || b > 64 || (b % 4) != 0) ok = 0;
      end
      if (!ok) begin m_fault = 1; return; end
      m_cfg = 1;
      for (int t = 0; t < NT; t++) begin
         m_rows[t] = sbuf[48+t];
         m_bpr[t]  = sbuf[16+2*t] + 256*sbuf[17+2*t];
      end
   endtask

   task automatic step(bit wl, logic [7:0] wb, bit rel, bit rs);
      ld_valid = wl; ld_byte = wb; release_req = rel; rd_start = rs;
      m_fault = 0; m_zero = 0;
      if (rel) begin clear_model(); m_zero = 1; m_idx = 0; end
      else if (wl) begin
         sbuf[m_idx] = wb;
         if (m_idx == 63) begin evaluate(); m_idx = 0; end
         else m_idx++;
      end
      if (m_rd) begin
         if (m_rdi == 63) begin m_rd = 0; m_rdi = 0; end
         else m_rdi++;
      end else if (rs) begin m_rd = 1; m_rdi = 0; end
      @(posedge clk);
      #1;
      compare_all();
   endtask

   task automatic new_img(logic [7:0] pal);
      for (int i = 0; i < 64; i++) img[i] = 8'd0;
      img[0] = pal;
   endtask

   task automatic set_tile(int t, int rows, int bpr);
      img[48+t]   = 8'(rows);
      img[16+2*t] = 8'(bpr % 256);
      img[17+2*t] = 8'(bpr / 256);
   endtask

   task automatic send(int rel_at);
      for (int i = 0; i < 64; i++) step(1'b1, img[i], i == rel_at, 1'b0);
      step(1'b0, 8'd0, 1'b0, 1'b0);
   endtask

   task automatic readback(int again_at, int rel_at);
      step(1'b0, 8'd0, 1'b0, 1'b1);
      for (int i = 0; i < 66; i++) step(1'b0, 8'd0, i == rel_at, i == again_at);
   endtask

   task automatic valid_a();
      new_img(8'd1);
      for (int t = 0; t < NT; t++) set_tile(t, t + 2, 4 * (t + 1));
   endtask

   initial begin
      clear_model();
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      tag = "R1"; compare_all();
      step(0, 0, 0, 0);

      tag = "R9"; readback(-1, -1);

      tag = "R3"; valid_a(); send(-1);
      tag = "R2"; new_img(8'd1); set_tile(0, 16, 64); set_tile(5, 1, 8); send(-1);

      tag = "R8"; valid_a(); send(-1); readback(10, -1);

      tag = "R5"; new_img(8'd2); set_tile(0, 4, 16); send(-1);
      new_img(8'd1); img[7] = 8'h01; send(-1);
      valid_a(); set_tile(3, 17, 16); send(-1);
      valid_a(); set_tile(6, 4, 68); send(-1);
      valid_a(); set_tile(2, 4, 6); send(-1);
      valid_a(); set_tile(7, 4, 256 + 4); send(-1);

      tag = "R10"; new_img(8'd1); set_tile(0, 16, 64); set_tile(1, 0, 0); set_tile(2, 16, 0);
      send(-1);

      tag = "R6"; valid_a();
      for (int i = 32; i < 48; i++) img[i] = 8'hA5;
      for (int i = 56; i < 64; i++) img[i] = 8'hFF;
      send(-1); readback(-1, -1);

      tag = "R4"; new_img(8'd0); img[5] = 8'h33; set_tile(1, 40, 99); send(-1);
      readback(-1, -1);

      tag = "R7"; valid_a(); send(-1);
      new_img(8'd1); set_tile(0, 8, 32);
      for (int i = 0; i < 20; i++) step(1'b1, img[i], 1'b0, 1'b0);
      step(1'b0, 8'd0, 1'b1, 1'b0);
      send(-1);
      new_img(8'd9); send(63);
      valid_a(); send(-1); readback(-1, 30);
      step(0, 0, 1, 0); step(0, 0, 0, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog %s run did not finish", tag);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule